// File: doc/BRIEF.md
# Constant-Weight Next-Subset Generator

This block steps through every way of choosing k positions out of a field of n bit positions, one choice per clock. The current choice is a W-bit word with exactly k ones. From it, the block computes the next word of the same weight in a fixed order, which is descending numeric order inside the field. It also raises a flag when the presented word is the final one. A repair search uses it as its strategy source: a one in a word means "take a spare row here" and a zero means "take a spare column".

The block also forms the starting word from the number of spare rows and spare columns still free. The ones sit at the top of the field and the field occupies bits [rows+cols-1:0]. W may be wider than the field, so the same hardware enumerates smaller spare budgets. Finding the pivot bit is a span-classification scan. The scan is a logarithmic parallel-prefix tree by default, and a ripple chain is available as a parameter choice. The results leave through a register stage that can be removed.

Top module: `ksub_next_gen`

## Requirements
- R1: When bit 0 of the current word is 0 and the word is nonzero, the next word equals the current word with its lowest one moved down by one position (for example 00001100 gives 00001010).
- R2: When bit 0 is 1 and the word is not final, consider the run of t ones that ends at bit 0. The pivot is the lowest one above that run. The pivot moves down one position, t ones are placed directly below its new position, and zeros fill the positions under them (for example 00100011 gives 00011100).
- R3: The next word always has the same number of ones as the current word.
- R4: The last flag is 1 exactly when the current word has the form zeros-then-ones with the ones reaching bit 0, including the all-zero word.
- R5: When the last flag is 1, the next word equals the current word.
- R6: With rows+cols no larger than W, the starting word has k=rows ones in bit positions [rows+cols-1 : cols] and zeros everywhere else.
- R7: Start from the starting word for any n=rows+cols and k=rows, and feed each next word back until the last flag. Every weight-k word inside the field then appears exactly once, and the number of words is C(n,k).
- R8: With REG_OUT=1, all outputs change one clock after the inputs. A synchronous active-high reset clears them to zero.
- R9: The prefix-tree variant (TREE=1) and the ripple variant (TREE=0) give identical outputs for every input word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the output register |
| cur_word | input | W | Current weight-k word |
| num_rows | input | CNTW | Spare rows available (k) |
| num_cols | input | CNTW | Spare columns available (n-k) |
| next_word | output | W | Next word in the enumeration |
| last_flag | output | 1 | Current word is the final one |
| init_word | output | W | Starting word for the given rows and columns |

## Verification
On every clock, the assertions check properties of a single step: the weight is preserved, the last flag matches the zeros-then-ones shape, the word is held on the last step, the plain down-move applies when bit 0 is 0, and the starting word has the right weight. Some properties only show across a whole walk, which only the bench's scenarios can show. These are that the walk visits each weight-k word of the field exactly once, that it stops after exactly C(n,k) words, and that the tree and ripple scans agree. The bench therefore sweeps every field size and every k for W=8.

// File: rtl/ksub_pkg.sv
package ksub_pkg;
  // Classification of a contiguous span of bits, read from its high end down.
  typedef enum logic [1:0] {
    SPAN_ZERO = 2'd0,  // all zeros
    SPAN_ONE  = 2'd1,  // all ones
    SPAN_ZONE = 2'd2,  // one or more zeros above one or more ones
    SPAN_MIX  = 2'd3   // anything else
  } span_e;

  function automatic span_e span_of_bit(input logic b);
    return b ? SPAN_ONE : SPAN_ZERO;
  endfunction

  // Concatenate a higher span over a lower span (associative).
  function automatic span_e span_join(input span_e hi, input span_e lo);
    span_e r;
    case (hi)
      SPAN_ZERO: r = (lo == SPAN_ZERO) ? SPAN_ZERO :
                     (lo == SPAN_MIX)  ? SPAN_MIX  : SPAN_ZONE;
      SPAN_ONE:  r = (lo == SPAN_ONE)  ? SPAN_ONE  : SPAN_MIX;
      SPAN_ZONE: r = (lo == SPAN_ONE)  ? SPAN_ZONE : SPAN_MIX;
      default:   r = SPAN_MIX;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/ksub_scan.sv
// Inclusive span class of bits [i:0] for every i, as a tree or a ripple chain.
module ksub_scan #(
  parameter int W    = 16,
  parameter int TREE = 1
) (
  input  logic [W-1:0]   word,
  output ksub_pkg::span_e incl [W]
);
  import ksub_pkg::*;

  if (TREE != 0) begin : g_tree
    localparam int LVL = (W > 1) ? $clog2(W) : 1;
    span_e lv [LVL+1][W];
    for (genvar i = 0; i < W; i++) begin : g_leaf
      assign lv[0][i] = span_of_bit(word[i]);
    end
    for (genvar d = 0; d < LVL; d++) begin : g_lvl
      for (genvar i = 0; i < W; i++) begin : g_node
        if (i >= (1 << d)) begin : g_join
          assign lv[d+1][i] = span_join(lv[d][i], lv[d][i-(1<<d)]);
        end else begin : g_pass
          assign lv[d+1][i] = lv[d][i];
        end
      end
    end
    for (genvar i = 0; i < W; i++) begin : g_out
      assign incl[i] = lv[LVL][i];
    end
  end else begin : g_ripple
    span_e chain [W];
    assign chain[0] = span_of_bit(word[0]);
    for (genvar i = 1; i < W; i++) begin : g_link
      assign chain[i] = span_join(span_of_bit(word[i]), chain[i-1]);
    end
    for (genvar i = 0; i < W; i++) begin : g_out
      assign incl[i] = chain[i];
    end
  end
endmodule

// File: rtl/ksub_step.sv
// Pivot selection and move/borrow rewrite of the word.
module ksub_step #(
  parameter int W = 16
) (
  input  logic [W-1:0]    word,
  input  ksub_pkg::span_e incl [W],
  output logic [W-1:0]    next,
  output logic            last
);
  import ksub_pkg::*;
  localparam int CW = $clog2(W + 1) + 1;

  logic [W-1:0]  pv;
  logic [W-1:0]  lowmask;
  logic [W-1:0]  run;
  logic [CW-1:0] tcnt;
  logic [CW-1:0] shamt;

  always_comb begin
    pv = '0;
    for (int i = 1; i < W; i++) begin
      if (word[i] && (incl[i-1] == SPAN_ZERO || incl[i-1] == SPAN_ZONE))
        pv[i] = 1'b1;
    end
    last    = ~|pv;
    lowmask = pv - 1'b1;
    tcnt    = CW'($countones(word & lowmask));
    shamt   = tcnt + 1'b1;
    run     = lowmask & ~(lowmask >> shamt);
    next    = last ? word : ((word & ~(pv | lowmask)) | run);
  end
endmodule

// File: rtl/ksub_seed.sv
// Starting word: rows ones placed just above cols zeros.
module ksub_seed #(
  parameter int W    = 16,
  parameter int CNTW = 5
) (
  input  logic [CNTW-1:0] rows,
  input  logic [CNTW-1:0] cols,
  output logic [W-1:0]    seed
);
  logic [W:0] ones_ext;
  always_comb begin
    ones_ext = ({{W{1'b0}}, 1'b1} << rows) - 1'b1;
    seed     = ones_ext[W-1:0] << cols;
  end
endmodule

// File: rtl/ksub_next_gen.sv
module ksub_next_gen #(
  parameter int  W       = 16,
  parameter int  TREE    = 1,
  parameter int  REG_OUT = 1,
  localparam int CNTW    = $clog2(W + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [W-1:0]    cur_word,
  input  logic [CNTW-1:0] num_rows,
  input  logic [CNTW-1:0] num_cols,
  output logic [W-1:0]    next_word,
  output logic            last_flag,
  output logic [W-1:0]    init_word
);
  import ksub_pkg::*;

  span_e      incl [W];
  logic [W-1:0] nxt_c;
  logic         last_c;
  logic [W-1:0] seed_c;

  ksub_scan #(.W(W), .TREE(TREE)) u_scan (.word(cur_word), .incl(incl));
  ksub_step #(.W(W)) u_step (.word(cur_word), .incl(incl), .next(nxt_c), .last(last_c));
  ksub_seed #(.W(W), .CNTW(CNTW)) u_seed (.rows(num_rows), .cols(num_cols), .seed(seed_c));

  if (REG_OUT != 0) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        next_word <= '0;
        last_flag <= 1'b0;
        init_word <= '0;
      end else begin
        next_word <= nxt_c;
        last_flag <= last_c;
        init_word <= seed_c;
      end
    end
  end else begin : g_comb
    assign next_word = nxt_c;
    assign last_flag = last_c;
    assign init_word = seed_c;
  end
endmodule

// File: rtl/ksub_next_chk.sv
module ksub_next_chk #(
  parameter int W       = 16,
  parameter int CNTW    = 5,
  parameter int REG_OUT = 1
) (
  input logic            clk,
  input logic            rst,
  input logic [W-1:0]    cur_word,
  input logic [CNTW-1:0] num_rows,
  input logic [CNTW-1:0] num_cols,
  input logic [W-1:0]    next_word,
  input logic            last_flag,
  input logic [W-1:0]    init_word
);
  logic         primed;
  logic [W-1:0] low_bit;
  logic [W-1:0] exp_down;
  logic [W-1:0] tail_test;
  int           budget;

  always_ff @(posedge clk) begin
    if (rst) primed <= 1'b0;
    else     primed <= 1'b1;
  end

  always_comb begin
    low_bit   = cur_word & (~cur_word + 1'b1);
    exp_down  = cur_word - low_bit + (low_bit >> 1);
    tail_test = cur_word & (cur_word + 1'b1);
    budget    = int'(num_rows) + int'(num_cols);
  end

  if (REG_OUT != 0) begin : g_props
    a_r1_lowest_one_steps_down: assert property (@(posedge clk) disable iff (rst)
      primed && !$past(cur_word[0]) && ($past(cur_word) != '0) |-> next_word == $past(exp_down));
    a_r3_weight_kept: assert property (@(posedge clk) disable iff (rst)
      primed |-> $countones(next_word) == $countones($past(cur_word)));
    a_r4_last_shape: assert property (@(posedge clk) disable iff (rst)
      primed |-> last_flag == ($past(tail_test) == '0));
    a_r5_hold_at_end: assert property (@(posedge clk) disable iff (rst)
      primed && last_flag |-> next_word == $past(cur_word));
    a_r2_order_descends: assert property (@(posedge clk) disable iff (rst)
      primed && !last_flag |-> next_word < $past(cur_word));
    a_r6_seed_weight: assert property (@(posedge clk) disable iff (rst)
      primed && ($past(budget) <= W) |-> $countones(init_word) == int'($past(num_rows)));
  end
endmodule

bind ksub_next_gen ksub_next_chk #(.W(W), .CNTW(CNTW), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst(rst), .cur_word(cur_word), .num_rows(num_rows), .num_cols(num_cols),
  .next_word(next_word), .last_flag(last_flag), .init_word(init_word)
);

// File: tb/tb_ksub_next_gen.sv
module tb_ksub_next_gen;
  localparam int W  = 8;
  localparam int CW = $clog2(W + 1);

  logic          clk = 1'b0;
  logic          rst;
  logic [W-1:0]  cur;
  logic [CW-1:0] rows, cols;
  logic [W-1:0]  nxt, init, nxt_r, init_r;
  logic          last, last_r;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  bit seen [256];

  always #4 clk = ~clk;

  ksub_next_gen #(.W(W), .TREE(1), .REG_OUT(1)) dut (
    .clk(clk), .rst(rst), .cur_word(cur), .num_rows(rows), .num_cols(cols),
    .next_word(nxt), .last_flag(last), .init_word(init));

  ksub_next_gen #(.W(W), .TREE(0), .REG_OUT(1)) dut_rip (
    .clk(clk), .rst(rst), .cur_word(cur), .num_rows(rows), .num_cols(cols),
    .next_word(nxt_r), .last_flag(last_r), .init_word(init_r));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] w);
    @(negedge clk);
    cur = w;
    @(negedge clk);
  endtask

  function automatic int binom(input int n, input int k);
    int r = 1;
    for (int i = 0; i < k; i++) r = r * (n - i) / (i + 1);
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] w, fmask, tail;
    int cnt;
    rst = 1'b1; cur = 8'b0000_1100; rows = 3; cols = 2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset clears all outputs
    check(nxt == 0 && last == 0 && init == 0, "R8 reset", {nxt, init}, 0);
    rst = 1'b0;

    // R8: one-cycle latency, output still old before the edge
    apply(8'b0000_1100);
    cur = 8'b0010_0011;
    #1;
    check(nxt == 8'b0000_1010, "R8 latency", nxt, 8'b0000_1010);
    @(negedge clk);
    // R2: borrow rule example
    check(nxt == 8'b0001_1100, "R2 borrow", nxt, 8'b0001_1100);
    // R1: move rule example
    apply(8'b0000_1100);
    check(nxt == 8'b0000_1010 && !last, "R1 move", nxt, 8'b0000_1010);
    apply(8'b1000_0001);
    check(nxt == 8'b0110_0000, "R2 single-run", nxt, 8'b0110_0000);
    // R4 R5: final shapes
    apply(8'b0000_0111);
    check(last && nxt == 8'b0000_0111, "R4 R5 final", nxt, 8'b0000_0111);
    apply(8'b0000_0000);
    check(last && nxt == 0, "R4 zero word", {7'b0, last}, 1);
    apply(8'b1111_1111);
    check(last && nxt == 8'hff, "R5 full word", nxt, 8'hff);

    for (int n = 1; n <= W; n++) begin
      for (int k = 0; k <= n; k++) begin
        rows = CW'(k); cols = CW'(n - k);
        fmask = W'((9'd1 << n) - 1);
        apply(8'h00);
        w = W'(((1 << k) - 1) << (n - k));
        // R6: starting word
        check(init == w && init_r == w, "R6 seed", init, w);
        for (int i = 0; i < 256; i++) seen[i] = 1'b0;
        cnt = 0;
        for (int s = 0; s < 300; s++) begin
          // R7: inside field, unseen; R3: weight k
          check((w & ~fmask) == 0 && !seen[w], "R7 unique", w, fmask);
          check($countones(w) == k, "R3 weight", $countones(w), k);
          seen[w] = 1'b1;
          cnt++;
          apply(w);
          tail = w & (w + 1'b1);
          // R4: flag matches shape
          check(last == (tail == 0), "R4 last", last, tail == 0);
          // R9: tree and ripple agree
          check(nxt == nxt_r && last == last_r, "R9 variants", nxt_r, nxt);
          if (last) begin
            check(nxt == w && w == W'((1 << k) - 1), "R5 hold", nxt, w);
            break;
          end
          w = nxt;
        end
        // R7: number of words equals the binomial coefficient
        check(cnt == binom(n, k), "R7 count", cnt, binom(n, k));
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule